// File: doc/BRIEF.md
# Scaled Saturating Fixed-Point ALU

This block is the arithmetic core of a fixed-point signal-processing datapath. Each accepted operation takes a 25-bit two's-complement source value, multiplies it by a power of two chosen by a 4-bit scale code, and combines it with a 25-bit destination value under a 3-bit operation code. The result is a 25-bit word, an overflow flag and a carry bit. Arithmetic results that do not fit in 25 bits are clamped to the nearest full-scale value instead of wrapping.

Both operands are widened to 28 bits inside the block. A scaled source can therefore grow past the 25-bit range without losing bits before the sum is range-checked. Load and absolute value are computed as sums with a zero destination. A left shift that pushes the source out of range then saturates and flags overflow in the same way as an ordinary sum. The limit operation drives the result to full scale of the source's sign. Its overflow flag reports whether a load of the same source and scale code would have overflowed.

Operands are presented with `in_valid` and registered on the next rising clock edge. Results appear one cycle later and stay unchanged until the next accepted operation.

Top module: `sfx_alu`

## Requirements
- R1: When `rst_n` is sampled low at a rising edge, `out_valid`, `result`, `ovf` and `carry` all become 0.
- R2: The scaled source is the source multiplied by 2^(2-code) for `scale` = 0..15. Codes 0 and 1 shift left by 2 and 1, code 2 passes the source through, and codes 3..15 arithmetic-shift right by 1..13, truncating toward minus infinity.
- R3: `op`=0 computes dst + scaled source and `op`=1 computes dst - scaled source.
- R4: An arithmetic result above 2^24-1 gives `result`=0x0FFFFFF and one below -2^24 gives `result`=0x1000000. In both cases `ovf`=1; otherwise `ovf`=0.
- R5: `op`=2 (load) and `op`=3 (absolute value) return 0 + scaled value. A left shift that leaves the 25-bit range therefore saturates with `ovf`=1.
- R6: `op`=3 and `op`=4 (absolute add, dst + scaled magnitude) take the magnitude of the source before scaling. The magnitude of -2^24 is +2^24.
- R7: `op`=5 (limit) gives 0x1000000 when source bit 24 is 1 and 0x0FFFFFF otherwise. `ovf` is set exactly when `op`=2 with the same source and scale would overflow.
- R8: `op`=6 gives dst XOR (scaled source bits 24:0) and `op`=7 gives dst AND (scaled source bits 24:0). Both leave `ovf`=0 and `carry`=0.
- R9: `carry` is bit 25 of the 25-bit unsigned sum. For add and absolute add this is dst + scaled[24:0]. For subtract it is dst + ~scaled[24:0] + 1, where 1 means no borrow. For load, absolute value and limit `carry` is 0.
- R10: An operation offered with `in_valid`=1 is reflected on `result`, `ovf` and `carry` after the next rising edge, with `out_valid`=1. While `in_valid`=0, `out_valid` is 0 and the other outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and codes are valid this cycle |
| op | input | 3 | Operation code (0..7) |
| scale | input | 4 | Scale code, factor 2^(2-scale) |
| src_a | input | 25 | Source operand, two's complement |
| dst_b | input | 25 | Destination operand, two's complement |
| out_valid | output | 1 | A new result is present |
| result | output | 25 | Saturated or logic result |
| ovf | output | 1 | Overflow flag |
| carry | output | 1 | Carry out of bit 24 |

## Verification
The bench targets left shifts by scale codes 0 and 1 that push a load or absolute value out of range. A design that wrapped instead of summing against zero would return a truncated value with `ovf` clear. It feeds the most negative source to the absolute operations, where a 25-bit negation would come back negative instead of saturating positive. Limit is driven with sources that would and would not overflow under load, which catches a design that always or never flags overflow. It also checks right shifts of negative values for floor truncation and add/subtract carry at the 25-bit wrap, where swapped borrow polarity or a missing inversion shows up at once.

// File: rtl/sfx_alu_pkg.sv
// Package of shared widths and the operation code type for the scaled ALU.
// Assumes a 25-bit datapath widened by three guard bits inside the block.
package sfx_alu_pkg;
    localparam int DW      = 25;         // architectural data width
    localparam int GUARD   = 3;          // extra high bits used internally
    localparam int EW      = DW + GUARD; // internal width
    localparam int SCW     = 4;          // scale code width
    localparam int SHL_MAX = 2;          // largest left shift (scale code 0)

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_LDA = 3'd2,
        OP_ABS = 3'd3,
        OP_ABA = 3'd4,
        OP_LIM = 3'd5,
        OP_XOR = 3'd6,
        OP_AND = 3'd7
    } alu_op_e;
endpackage

// File: rtl/sfx_mag.sv
// Optional magnitude stage: returns |a| when en_i is set, else a unchanged.
// Assumes the input is already sign-extended so that -2^(DW-1) negates safely.
module sfx_mag #(
    parameter int EW = 28
) (
    input  logic signed [EW-1:0] a_i,
    input  logic                 en_i,
    output logic signed [EW-1:0] y_o
);
    // Negate negative inputs when the magnitude is requested.
    always_comb begin
        if (en_i && a_i[EW-1]) y_o = -a_i;
        else                   y_o = a_i;
    end
endmodule

// File: rtl/sfx_scaler.sv
// Power-of-two scaler: y = a * 2^(SHL_MAX - code). Left shifts for small codes,
// arithmetic right shifts (floor) for larger ones. Assumes enough guard bits in
// EW to hold a left shift of SHL_MAX without loss.
module sfx_scaler #(
    parameter int EW      = 28,
    parameter int SCW     = 4,
    parameter int SHL_MAX = 2
) (
    input  logic signed [EW-1:0]  a_i,
    input  logic        [SCW-1:0] code_i,
    output logic signed [EW-1:0]  y_o
);
    localparam logic [SCW-1:0] PIVOT = SCW'(SHL_MAX);

    // Pick the shift direction and distance from the code.
    always_comb begin
        if (code_i <= PIVOT) y_o = a_i <<< (PIVOT - code_i);
        else                 y_o = a_i >>> (code_i - PIVOT);
    end
endmodule

// File: rtl/sfx_satadd.sv
// Wide add/subtract with clamping to the DW-bit range, an overflow flag and a
// carry out of bit DW-1. Assumes EW > DW so the wide sum itself cannot wrap.
module sfx_satadd #(
    parameter int DW = 25,
    parameter int EW = 28
) (
    input  logic signed [EW-1:0] x_i,
    input  logic signed [EW-1:0] y_i,
    input  logic                 sub_i,
    output logic        [DW-1:0] sum_o,
    output logic                 ovf_o,
    output logic                 carry_o
);
    localparam int GB = EW - DW;
    localparam logic signed [EW-1:0] HI = {{(GB+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [EW-1:0] LO = {{(GB+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [EW-1:0] wide;
    logic        [DW:0]   narrow;

    // Exact wide sum, then range check and clamp.
    always_comb begin
        wide = sub_i ? (x_i - y_i) : (x_i + y_i);
        if (wide > HI) begin
            sum_o = HI[DW-1:0];
            ovf_o = 1'b1;
        end else if (wide < LO) begin
            sum_o = LO[DW-1:0];
            ovf_o = 1'b1;
        end else begin
            sum_o = wide[DW-1:0];
            ovf_o = 1'b0;
        end
    end

    // Unsigned DW-bit sum used only for its carry out.
    always_comb begin
        narrow  = {1'b0, x_i[DW-1:0]}
                + {1'b0, (sub_i ? ~y_i[DW-1:0] : y_i[DW-1:0])}
                + {{DW{1'b0}}, sub_i};
        carry_o = narrow[DW];
    end
endmodule

// File: rtl/sfx_alu.sv
// Scaled saturating fixed-point ALU. The source is optionally made positive,
// scaled by a power of two and combined with the destination; arithmetic
// results clamp to full scale. Inputs are registered with a one-cycle latency.
// Assumes in_valid qualifies op, scale, src_a and dst_b in the same cycle.
module sfx_alu
    import sfx_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    op,
    input  logic [3:0]    scale,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] dst_b,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          ovf,
    output logic          carry
);
    localparam logic [DW-1:0] FS_POS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] FS_NEG = {1'b1, {(DW-1){1'b0}}};

    alu_op_e              opc;
    logic signed [EW-1:0] a_ext, b_ext, a_mag, a_scl, x_sel;
    logic                 use_mag, zero_dst;
    logic        [DW-1:0] add_sum, nx_res;
    logic                 add_ovf, add_cy, nx_ovf, nx_cy;

    // Decode the opcode and widen both operands by sign extension.
    always_comb begin
        opc      = alu_op_e'(op);
        a_ext    = {{GUARD{src_a[DW-1]}}, src_a};
        b_ext    = {{GUARD{dst_b[DW-1]}}, dst_b};
        use_mag  = (opc == OP_ABS) || (opc == OP_ABA);
        zero_dst = (opc == OP_LDA) || (opc == OP_ABS) || (opc == OP_LIM);
        x_sel    = zero_dst ? '0 : b_ext;
    end

    sfx_mag #(.EW(EW)) u_mag (
        .a_i (a_ext),
        .en_i(use_mag),
        .y_o (a_mag)
    );

    sfx_scaler #(.EW(EW), .SCW(SCW), .SHL_MAX(SHL_MAX)) u_scl (
        .a_i   (a_mag),
        .code_i(scale),
        .y_o   (a_scl)
    );

    sfx_satadd #(.DW(DW), .EW(EW)) u_add (
        .x_i    (x_sel),
        .y_i    (a_scl),
        .sub_i  (opc == OP_SUB),
        .sum_o  (add_sum),
        .ovf_o  (add_ovf),
        .carry_o(add_cy)
    );

    // Select the final result, flag and carry per operation.
    always_comb begin
        nx_res = add_sum;
        nx_ovf = add_ovf;
        nx_cy  = add_cy;
        case (opc)
            OP_LDA, OP_ABS: nx_cy = 1'b0;
            OP_LIM: begin
                nx_res = src_a[DW-1] ? FS_NEG : FS_POS;
                nx_cy  = 1'b0;
            end
            OP_XOR: begin
                nx_res = dst_b ^ a_scl[DW-1:0];
                nx_ovf = 1'b0;
                nx_cy  = 1'b0;
            end
            OP_AND: begin
                nx_res = dst_b & a_scl[DW-1:0];
                nx_ovf = 1'b0;
                nx_cy  = 1'b0;
            end
            default: ;
        endcase
    end

    // Output register: cleared by reset, loaded on each valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf       <= 1'b0;
            carry     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nx_res;
                ovf    <= nx_ovf;
                carry  <= nx_cy;
            end
        end
    end

    // R4
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf) |-> (result == FS_POS || result == FS_NEG));

    // R7
    lim_fullscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd5) |=>
            (result == ($past(src_a[DW-1]) ? FS_NEG : FS_POS)));

    // R8
    logic_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2:1] == 2'b11) |=> (!ovf && !carry));

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(ovf) && $stable(carry)));
endmodule

// File: tb/sfx_alu_tb.sv
// Scoreboard bench: the driver pushes model results, the monitor compares them.
module sfx_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [3:0]  scale = '0;
    logic [24:0] src_a = '0;
    logic [24:0] dst_b = '0;
    logic        out_valid, ovf, carry;
    logic [24:0] result;

    int total = 0;
    int bad = 0;
    logic [26:0] exp_q[$];
    string       tag_q[$];
    logic [24:0] last_res = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sfx_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .scale(scale),
        .src_a(src_a), .dst_b(dst_b), .out_valid(out_valid), .result(result),
        .ovf(ovf), .carry(carry)
    );

    // Reference model built from the requirements: returns {carry, ovf, result}.
    function automatic logic [26:0] model(input logic [2:0] o, input logic [3:0] c,
                                          input logic [24:0] a, input logic [24:0] b);
        longint sa, sb, sc, s, m;
        logic   v, cy;
        logic [24:0] r;
        m  = 64'h1FFFFFF;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if ((o == 3 || o == 4) && sa < 0) sa = -sa;
        if (c <= 2) sc = sa <<< (2 - c);
        else        sc = sa >>> (c - 2);
        cy = 1'b0;
        case (o)
            0, 4: begin s = sb + sc; cy = (((sb & m) + (sc & m)) >> 25) & 1; end
            1:    begin s = sb - sc; cy = (((sb & m) + ((~sc) & m) + 1) >> 25) & 1; end
            default: s = sc;
        endcase
        v = (s > 64'sd16777215) || (s < -64'sd16777216);
        if (s > 64'sd16777215)       r = 25'h0FFFFFF;
        else if (s < -64'sd16777216) r = 25'h1000000;
        else                         r = s[24:0];
        if (o == 5) r = a[24] ? 25'h1000000 : 25'h0FFFFFF;
        if (o == 6) begin r = b ^ sc[24:0]; v = 1'b0; end
        if (o == 7) begin r = b & sc[24:0]; v = 1'b0; end
        return {cy, v, r};
    endfunction

    // Driver: apply one operation for one cycle and push its expected result.
    task automatic drive(input logic [2:0] o, input logic [3:0] c,
                         input logic [24:0] a, input logic [24:0] b, input string tag);
        @(negedge clk);
        in_valid = 1'b1; op = o; scale = c; src_a = a; dst_b = b;
        exp_q.push_back(model(o, c, a, b));
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each result with the scoreboard, check holds when idle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                logic [26:0] e;
                string t;
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R10: unexpected out_valid, actual=%h expected=none", result);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({carry, ovf, result} !== e) begin
                        bad++;
                        $display("FAIL %s: actual c=%b v=%b r=%h expected c=%b v=%b r=%h",
                                 t, carry, ovf, result, e[26], e[25], e[24:0]);
                    end
                    last_res = e[24:0];
                end
            end else if (!in_valid) begin
                total++;
                if (result !== last_res) begin
                    bad++;
                    $display("FAIL R10: idle hold actual=%h expected=%h", result, last_res);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state before any operation
        total++;
        if ({out_valid, carry, ovf, result} !== 28'd0) begin
            bad++;
            $display("FAIL R1: actual=%h expected=0", {out_valid, carry, ovf, result});
        end
        // R3 add and subtract
        drive(3'd0, 4'd2, 25'd100, 25'd200, "R3");
        drive(3'd1, 4'd2, 25'd300, 25'd200, "R3");
        drive(3'd0, 4'd2, -25'sd7, 25'd5, "R3");
        // R2 every scale code, positive and negative source
        for (int k = 0; k < 16; k++) drive(3'd2, 4'(k), 25'h012345, 25'd0, "R2");
        for (int k = 0; k < 16; k++) drive(3'd2, 4'(k), -25'sd12345, 25'd0, "R2");
        drive(3'd2, 4'd3, -25'sd3, 25'd0, "R2");
        // R4 saturation both ways
        drive(3'd0, 4'd2, 25'h0FFFFFF, 25'd1, "R4");
        drive(3'd1, 4'd2, 25'd2, 25'h1000000, "R4");
        drive(3'd0, 4'd0, 25'h0200000, 25'h0F00000, "R4");
        // R5 shift-induced overflow of load and absolute value
        drive(3'd2, 4'd0, 25'h0800000, 25'd0, "R5");
        drive(3'd2, 4'd1, 25'h1400000, 25'd0, "R5");
        drive(3'd3, 4'd0, 25'h1C00000, 25'd0, "R5");
        drive(3'd2, 4'd0, 25'h0100000, 25'd0, "R5");
        // R6 magnitude before scaling
        drive(3'd3, 4'd2, -25'sd5, 25'd123, "R6");
        drive(3'd3, 4'd2, 25'h1000000, 25'd0, "R6");
        drive(3'd3, 4'd4, 25'h1000000, 25'd0, "R6");
        drive(3'd4, 4'd3, -25'sd40, 25'd10, "R6");
        drive(3'd4, 4'd2, -25'sd1, -25'sd1, "R6");
        // R7 limit with and without load overflow
        drive(3'd5, 4'd2, -25'sd1, 25'd9, "R7");
        drive(3'd5, 4'd2, 25'd1, 25'd9, "R7");
        drive(3'd5, 4'd0, 25'h0800000, 25'd9, "R7");
        drive(3'd5, 4'd0, 25'h1400000, 25'd9, "R7");
        // R8 logic operations
        drive(3'd6, 4'd2, 25'h155AA55, 25'h0F0F0F0, "R8");
        drive(3'd7, 4'd1, 25'h0ABCDEF, 25'h1FFFFFF, "R8");
        drive(3'd6, 4'd0, 25'h0C00000, 25'h0000001, "R8");
        // R9 carry polarity
        drive(3'd0, 4'd2, 25'd1, -25'sd1, "R9");
        drive(3'd1, 4'd2, 25'd3, 25'd5, "R9");
        drive(3'd1, 4'd2, 25'd5, 25'd3, "R9");
        drive(3'd1, 4'd2, 25'd0, 25'd0, "R9");
        // R10 back-to-back operations then idle cycles
        @(negedge clk);
        in_valid = 1'b1; op = 3'd0; scale = 4'd2; src_a = 25'd1; dst_b = 25'd2;
        exp_q.push_back(model(3'd0, 4'd2, 25'd1, 25'd2)); tag_q.push_back("R10");
        @(negedge clk);
        op = 3'd1; src_a = 25'd9; dst_b = 25'd4;
        exp_q.push_back(model(3'd1, 4'd2, 25'd9, 25'd4)); tag_q.push_back("R10");
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R10: pending results actual=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule